// File: doc/BRIEF.md
# Floating-Point to Integer Conversion Unit

This unit accepts one IEEE-754 operand per cycle, in either single or double precision, and turns it into a signed integer that is 32 or 64 bits wide. The rounding is chosen per operation. It can truncate, round down, round up, round to nearest with ties going to the even integer, or follow the rounding mode currently held in the unit's control/status register. Each result is registered. It leaves the unit one cycle after the request, together with an invalid indication.

The control/status register holds a two-bit rounding-mode field and four sticky exception flags. A conversion can only set flags. Software clears them, or changes the mode, through a single write port that replaces the whole register. When a conversion cannot be represented, the unit drives a fixed saturation pattern of the destination width instead of a number. Such a conversion is a NaN, an infinity, or a rounded value that reaches either integer limit. The largest positive integer itself counts as out of range.

Top module: `f2i_convert`

## Requirements
- R1: With `src_dbl`=1 the operand is a double taken from all 64 bits. With `src_dbl`=0 it is a single taken from bits [31:0]. Subnormal and signed-zero operands convert by their value.
- R2: `cvt_op` codes: 0 truncates toward zero, 1 rounds toward minus infinity, 2 rounds toward plus infinity, 3 rounds to nearest and 4 uses the register's mode field. Codes 5 to 7 truncate.
- R3: Nearest rounding breaks an exact tie toward the even integer: 2.5 gives 2, 3.5 gives 4 and -2.5 gives -2.
- R4: With N the destination width, the conversion is invalid and sets both the overflow flag and the invalid flag when one of these holds: the operand is infinite, the rounded value is at least 2^(N-1)-1, or the rounded value is at most -2^(N-1).
- R5: A NaN operand makes the conversion invalid and sets the invalid flag and the inexact flag. It does not set the overflow flag.
- R6: An invalid conversion returns 0x7FFFFFFF for a 32-bit destination and 0x7FFFFFFFFFFFFFFF for a 64-bit one. Both are zero-extended to 64 bits.
- R7: The inexact flag is set whenever the rounded value differs from a finite operand. No conversion ever sets the underflow flag.
- R8: Flags are sticky. Without a write, a conversion only ORs new flags into the register and never changes the mode field. A write replaces the whole register, and flags from a conversion in the same cycle are ORed on top of the written value.
- R9: `out_valid` rises exactly one cycle after `in_valid` and is low otherwise. The result, `out_invalid` and the flag update all commit on that same clock edge. A conversion uses the mode held before any write in its own cycle.
- R10: A valid 32-bit result is sign-extended to 64 bits on `result`.
- R11: Register layout: bits [1:0] hold the mode (0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity). Bit 2 is inexact, bit 3 is underflow, bit 4 is overflow and bit 5 is invalid.
- R12: Under code 4 the four modes behave like codes 3, 0, 2 and 1 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Conversion request this cycle |
| src_dbl | input | 1 | 1: double operand, 0: single in bits [31:0] |
| cvt_op | input | 3 | Rounding operation select |
| dst_wide | input | 1 | 1: 64-bit destination, 0: 32-bit |
| operand | input | 64 | Floating-point operand bits |
| csr_we | input | 1 | Replace the control/status register |
| csr_wdata | input | 6 | Value written when `csr_we` is high |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Integer result or saturation pattern |
| out_invalid | output | 1 | Registered conversion was invalid |
| csr | output | 6 | Control/status register contents |

## Verification
The hardest cases to reach are the ones that sit exactly on an integer limit. A double equal to 2^31-1 must be rejected, while 2^31-2 must pass. A value a half below the limit must pass when truncated but overflow when rounded up. A conversion must also read the old mode while a write to the register lands in the same cycle. The stimulus builds the limit operands from exact quarter-step magnitudes and from hand-built exponent fields. It then sweeps every operation code against both source formats and both destination widths over a dense grid of quarter steps. A dedicated sequence issues a conversion and a mode change in the same cycle and checks that the old mode was used.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
  localparam int WIDE_W   = 64;
  localparam int NARROW_W = 32;
  localparam int D_EXP_W  = 11;
  localparam int D_FRAC_W = 52;
  localparam int S_EXP_W  = 8;
  localparam int S_FRAC_W = 23;
  localparam int D_BIAS   = (1 << (D_EXP_W - 1)) - 1;
  localparam int S_BIAS   = (1 << (S_EXP_W - 1)) - 1;
  localparam int MANT_W   = D_FRAC_W + 1;
  localparam int EXP_W    = D_EXP_W + 2;
  localparam int MAG_W    = WIDE_W + 1;
  localparam int MODE_W   = 2;
  localparam int FLAG_W   = 4;
  localparam int CSR_W    = MODE_W + FLAG_W;
  localparam int FLG_INX  = MODE_W;
  localparam int FLG_UDF  = MODE_W + 1;
  localparam int FLG_OVF  = MODE_W + 2;
  localparam int FLG_INV  = MODE_W + 3;

  localparam logic [2:0] OP_TRUNC = 3'd0;
  localparam logic [2:0] OP_FLOOR = 3'd1;
  localparam logic [2:0] OP_CEIL  = 3'd2;
  localparam logic [2:0] OP_EVEN  = 3'd3;
  localparam logic [2:0] OP_DYN   = 3'd4;

  typedef enum logic [MODE_W-1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  // unpacked operand: value = mant * 2^(exp - D_FRAC_W)
  typedef struct packed {
    logic                    neg;
    logic                    nan;
    logic                    inf;
    logic signed [EXP_W-1:0] exp;
    logic [MANT_W-1:0]       mant;
  } unp_t;

  // integer part plus round and sticky bits
  typedef struct packed {
    logic [WIDE_W-1:0] ip;
    logic              rb;
    logic              sb;
    logic              huge;
  } split_t;

  function automatic rmode_e op_to_mode(logic [2:0] op, rmode_e dyn);
    case (op)
      OP_TRUNC: return RM_ZERO;
      OP_FLOOR: return RM_DOWN;
      OP_CEIL:  return RM_UP;
      OP_EVEN:  return RM_NEAR;
      OP_DYN:   return dyn;
      default:  return RM_ZERO;
    endcase
  endfunction

  // split the fixed-point value at the binary point
  function automatic split_t split_fixed(logic signed [EXP_W-1:0] e,
                                         logic [MANT_W-1:0] m);
    split_t            s;
    logic [WIDE_W-1:0] m64;
    int                ei;
    int                k;
    s   = '0;
    m64 = WIDE_W'(m);
    ei  = int'(e);
    if (ei >= WIDE_W) begin
      s.huge = 1'b1;
    end else if (ei >= D_FRAC_W) begin
      s.ip = m64 << (ei - D_FRAC_W);
    end else if (ei >= -1) begin
      k    = D_FRAC_W - ei;
      s.ip = m64 >> k;
      s.rb = m64[k-1];
      s.sb = |(m64 & ((WIDE_W'(1) << (k - 1)) - WIDE_W'(1)));
    end else begin
      s.sb = |m;
    end
    return s;
  endfunction

  function automatic logic round_inc(rmode_e rm, logic neg, logic lsb,
                                     logic rb, logic sb);
    case (rm)
      RM_NEAR: return rb & (sb | lsb);
      RM_ZERO: return 1'b0;
      RM_UP:   return ~neg & (rb | sb);
      default: return neg & (rb | sb);
    endcase
  endfunction
endpackage

// File: rtl/f2i_unpack.sv
`timescale 1ns/1ps
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic        src_dbl,
  input  logic [63:0] operand,
  output unp_t        unp
);
  logic [D_EXP_W-1:0]  d_e;
  logic [D_FRAC_W-1:0] d_f;
  logic [S_EXP_W-1:0]  s_e;
  logic [S_FRAC_W-1:0] s_f;
  logic signed [EXP_W-1:0] d_exp;
  logic signed [EXP_W-1:0] s_exp;

  assign d_e = operand[62:52];
  assign d_f = operand[51:0];
  assign s_e = operand[30:23];
  assign s_f = operand[22:0];

  assign d_exp = (d_e == '0) ? EXP_W'(1 - D_BIAS)
                             : $signed(EXP_W'(d_e)) - EXP_W'(D_BIAS);
  assign s_exp = (s_e == '0) ? EXP_W'(1 - S_BIAS)
                             : $signed(EXP_W'(s_e)) - EXP_W'(S_BIAS);

  always_comb begin
    if (src_dbl) begin
      unp.neg  = operand[63];
      unp.nan  = (&d_e) & (|d_f);
      unp.inf  = (&d_e) & ~(|d_f);
      unp.exp  = d_exp;
      unp.mant = {d_e != '0, d_f};
    end else begin
      unp.neg  = operand[31];
      unp.nan  = (&s_e) & (|s_f);
      unp.inf  = (&s_e) & ~(|s_f);
      unp.exp  = s_exp;
      unp.mant = {s_e != '0, s_f, {(MANT_W - 1 - S_FRAC_W){1'b0}}};
    end
  end
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
  import f2i_pkg::*;
(
  input  unp_t             unp,
  input  rmode_e           rm,
  output logic [MAG_W-1:0] mag,
  output logic             frac_nz,
  output logic             huge
);
  split_t sp;
  logic   inc;

  assign sp      = split_fixed(unp.exp, unp.mant);
  assign inc     = round_inc(rm, unp.neg, sp.ip[0], sp.rb, sp.sb);
  assign mag     = {1'b0, sp.ip} + MAG_W'(inc);
  assign frac_nz = sp.rb | sp.sb;
  assign huge    = sp.huge;
endmodule

// File: rtl/f2i_pack.sv
`timescale 1ns/1ps
module f2i_pack
  import f2i_pkg::*;
(
  input  logic              neg,
  input  logic              nan,
  input  logic              inf,
  input  logic              huge,
  input  logic              frac_nz,
  input  logic [MAG_W-1:0]  mag,
  input  logic              dst_wide,
  output logic [WIDE_W-1:0] value,
  output logic              invalid,
  output logic              evt_ovf,
  output logic [FLAG_W-1:0] flags
);
  logic [WIDE_W-1:0] val_g [2];
  logic              ovf_g [2];
  logic              evt_inx;

  for (genvar g = 0; g < 2; g++) begin : g_dst
    localparam int N = (g == 1) ? WIDE_W : NARROW_W;
    localparam logic [MAG_W-1:0] LIM = MAG_W'(1) << (N - 1);
    localparam logic [N-1:0] SENT = {1'b0, {(N - 1){1'b1}}};
    logic [N-1:0]             tv;
    logic signed [WIDE_W-1:0] ext;
    logic                     rng;
    assign rng = neg ? (mag >= LIM) : (mag >= LIM - MAG_W'(1));
    assign ovf_g[g] = ~nan & (huge | inf | rng);
    assign tv  = neg ? -mag[N-1:0] : mag[N-1:0];
    assign ext = WIDE_W'($signed(tv));
    assign val_g[g] = (nan | ovf_g[g]) ? WIDE_W'(SENT) : ext;
  end

  assign evt_ovf = ovf_g[dst_wide];
  assign value   = val_g[dst_wide];
  assign invalid = nan | evt_ovf;
  assign evt_inx = nan | (~inf & frac_nz);
  // bit order follows the register: inexact, underflow, overflow, invalid
  assign flags   = {invalid, evt_ovf, 1'b0, evt_inx};
endmodule

// File: rtl/f2i_convert.sv
`timescale 1ns/1ps
module f2i_convert
  import f2i_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              src_dbl,
  input  logic [2:0]        cvt_op,
  input  logic              dst_wide,
  input  logic [63:0]       operand,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic              out_valid,
  output logic [63:0]       result,
  output logic              out_invalid,
  output logic [CSR_W-1:0]  csr
);
  unp_t              unp;
  rmode_e            rm_eff;
  logic [MAG_W-1:0]  mag;
  logic              frac_nz;
  logic              huge;
  logic [WIDE_W-1:0] cvt_value;
  logic              cvt_invalid;
  logic              evt_ovf;
  logic [FLAG_W-1:0] cvt_flags;
  logic [CSR_W-1:0]  csr_base;
  logic [CSR_W-1:0]  csr_next;
  logic              dst_wide_q;

  assign rm_eff = op_to_mode(cvt_op, rmode_e'(csr[MODE_W-1:0]));

  f2i_unpack u_unpack (
    .src_dbl (src_dbl),
    .operand (operand),
    .unp     (unp)
  );

  f2i_round u_round (
    .unp     (unp),
    .rm      (rm_eff),
    .mag     (mag),
    .frac_nz (frac_nz),
    .huge    (huge)
  );

  f2i_pack u_pack (
    .neg      (unp.neg),
    .nan      (unp.nan),
    .inf      (unp.inf),
    .huge     (huge),
    .frac_nz  (frac_nz),
    .mag      (mag),
    .dst_wide (dst_wide),
    .value    (cvt_value),
    .invalid  (cvt_invalid),
    .evt_ovf  (evt_ovf),
    .flags    (cvt_flags)
  );

  assign csr_base = csr_we ? csr_wdata : csr;

  always_comb begin
    csr_next = csr_base;
    if (in_valid) csr_next[CSR_W-1:MODE_W] = csr_base[CSR_W-1:MODE_W] | cvt_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      result      <= '0;
      out_invalid <= 1'b0;
      dst_wide_q  <= 1'b0;
      csr         <= '0;
    end else begin
      out_valid <= in_valid;
      csr       <= csr_next;
      if (in_valid) begin
        result      <= cvt_value;
        out_invalid <= cvt_invalid;
        dst_wide_q  <= dst_wide;
      end
    end
  end
endmodule

// File: rtl/f2i_convert_chk.sv
`timescale 1ns/1ps
module f2i_convert_chk
  import f2i_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             csr_we,
  input logic             out_valid,
  input logic             out_invalid,
  input logic [63:0]      result,
  input logic [CSR_W-1:0] csr,
  input logic             dst_wide_q,
  input logic             evt_ovf
);
  localparam logic [63:0] SENT_W = {1'b0, {(WIDE_W - 1){1'b1}}};
  localparam logic [63:0] SENT_N = 64'({1'b0, {(NARROW_W - 1){1'b1}}});

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (result == (dst_wide_q ? SENT_W : SENT_N)));
  a_r5_invalid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> csr[FLG_INV]);
  a_r4_ovf_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && evt_ovf) |=> (csr[FLG_OVF] && csr[FLG_INV]));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> ((csr[CSR_W-1:MODE_W] & $past(csr[CSR_W-1:MODE_W])) ==
                 $past(csr[CSR_W-1:MODE_W])));
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> $stable(csr[MODE_W-1:0]));
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> !(csr[FLG_UDF] && !$past(csr[FLG_UDF])));
  a_r10_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid && !dst_wide_q) |-> (result[63:32] == {32{result[31]}}));
endmodule

bind f2i_convert f2i_convert_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .csr_we      (csr_we),
  .out_valid   (out_valid),
  .out_invalid (out_invalid),
  .result      (result),
  .csr         (csr),
  .dst_wide_q  (dst_wide_q),
  .evt_ovf     (evt_ovf)
);

// File: tb/tb_f2i_convert.sv
`timescale 1ns/1ps
module tb_f2i_convert;
  localparam int CLK_PERIOD_NS = 10;
  localparam logic [5:0] F_INX = 6'b000100;
  localparam logic [5:0] F_OVF = 6'b010000;
  localparam logic [5:0] F_INV = 6'b100000;
  localparam logic [63:0] S64 = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] S32 = 64'h0000_0000_7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        src_dbl = 1'b0;
  logic [2:0]  cvt_op = 3'd0;
  logic        dst_wide = 1'b0;
  logic [63:0] operand = '0;
  logic        csr_we = 1'b0;
  logic [5:0]  csr_wdata = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        out_invalid;
  logic [5:0]  csr;

  int n_vec = 0;
  int n_bad = 0;
  logic [1:0] cur_mode = 2'd0;

  always #(CLK_PERIOD_NS / 2) clk = ~clk;

  f2i_convert dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_dbl(src_dbl),
    .cvt_op(cvt_op), .dst_wide(dst_wide), .operand(operand),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .out_valid(out_valid),
    .result(result), .out_invalid(out_invalid), .csr(csr)
  );

  // magnitude given in quarter units
  function automatic logic [63:0] enc(bit dbl, bit neg, longint unsigned mq);
    int p;
    logic [63:0] al;
    int e;
    if (mq == 0) return dbl ? {neg, 63'b0} : {32'b0, neg, 31'b0};
    p = 0;
    for (int i = 0; i < 64; i++) if (mq[i]) p = i;
    al = mq << (63 - p);
    e  = p - 2;
    if (dbl) return {neg, 11'(1023 + e), al[62:11]};
    return {32'b0, neg, 8'(127 + e), al[62:40]};
  endfunction

  task automatic apply(string tag, logic [63:0] opnd, bit dbl, logic [2:0] opc,
                       bit wide, bit we, logic [5:0] wd, logic [63:0] exp_res,
                       bit exp_inv, logic [5:0] exp_csr);
    @(negedge clk);
    operand = opnd; src_dbl = dbl; cvt_op = opc; dst_wide = wide;
    in_valid = 1'b1; csr_we = we; csr_wdata = wd;
    @(negedge clk);
    in_valid = 1'b0; csr_we = 1'b0;
    n_vec++;
    if (out_valid !== 1'b1 || result !== exp_res || out_invalid !== exp_inv ||
        csr !== exp_csr) begin
      n_bad++;
      $display("FAIL %s op=%0d dbl=%0d wide=%0d in=%h: got v=%b res=%h inv=%b csr=%b, want res=%h inv=%b csr=%b",
               tag, opc, dbl, wide, opnd, out_valid, result, out_invalid, csr,
               exp_res, exp_inv, exp_csr);
    end
  endtask

  task automatic conv(string tag, bit dbl, bit neg, longint unsigned mq,
                      logic [2:0] opc, bit wide);
    logic [1:0] rm;
    longint unsigned ip;
    longint unsigned mag;
    int fr;
    logic inc;
    logic [64:0] lim;
    logic ovf;
    logic [63:0] v;
    logic [63:0] er;
    case (opc)
      3'd0: rm = 2'd1;
      3'd1: rm = 2'd3;
      3'd2: rm = 2'd2;
      3'd3: rm = 2'd0;
      3'd4: rm = cur_mode;
      default: rm = 2'd1;
    endcase
    ip = mq >> 2;
    fr = int'(mq & 64'd3);
    case (rm)
      2'd0: inc = (fr > 2) || (fr == 2 && ip[0]);
      2'd1: inc = 1'b0;
      2'd2: inc = !neg && fr != 0;
      default: inc = neg && fr != 0;
    endcase
    mag = ip + 64'(inc);
    lim = 65'(1) << (wide ? 63 : 31);
    ovf = neg ? ({1'b0, mag} >= lim) : ({1'b0, mag} >= lim - 65'd1);
    v = neg ? -mag : mag;
    if (!wide) v = {{32{v[31]}}, v[31:0]};
    er = ovf ? (wide ? S64 : S32) : v;
    apply(tag, enc(dbl, neg, mq), dbl, opc, wide, 1'b1, {4'b0, cur_mode}, er, ovf,
          (ovf ? (F_OVF | F_INV) : 6'b0) | ((fr != 0) ? F_INX : 6'b0) | {4'b0, cur_mode});
  endtask

  task automatic write_csr(logic [5:0] wd);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = wd;
    @(negedge clk);
    csr_we = 1'b0;
    n_vec++;
    if (csr !== wd || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 csr write: got csr=%b v=%b, want csr=%b v=0", csr, out_valid, wd);
    end
    cur_mode = wd[1:0];
  endtask

  initial begin
    #(CLK_PERIOD_NS * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || csr !== 6'b0 || result !== 64'b0 || out_invalid !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset: got v=%b csr=%b res=%h, want 0", out_valid, csr, result);
    end

    // R1 R2 R3 R7 R10: quarter-step grid, every op, both formats and widths
    for (int n = -40; n <= 40; n++)
      for (int o = 0; o < 8; o++)
        for (int d = 0; d < 2; d++)
          for (int w = 0; w < 2; w++)
            conv(o == 3 ? "R3" : (w == 0 ? "R10" : "R2"), d[0], n < 0,
                 64'(n < 0 ? -n : n), 3'(o), w[0]);

    // R12: register-selected modes
    for (int m = 0; m < 4; m++) begin
      write_csr({4'b0, 2'(m)});
      for (int n = -12; n <= 12; n++)
        conv("R12", 1'b1, n < 0, 64'(n < 0 ? -n : n), 3'd4, 1'b0);
    end
    write_csr(6'b0);

    // R4: limits of the 32-bit destination
    conv("R4", 1'b1, 1'b0, 64'h7FFF_FFFF * 4, 3'd0, 1'b0);
    conv("R4", 1'b1, 1'b0, 64'h7FFF_FFFE * 4, 3'd0, 1'b0);
    conv("R4", 1'b1, 1'b1, 64'h8000_0000 * 4, 3'd0, 1'b0);
    conv("R4", 1'b1, 1'b1, 64'h7FFF_FFFF * 4, 3'd0, 1'b0);
    conv("R4", 1'b1, 1'b0, 64'h7FFF_FFFE * 4 + 2, 3'd2, 1'b0);
    conv("R4", 1'b1, 1'b0, 64'h7FFF_FFFE * 4 + 2, 3'd0, 1'b0);
    conv("R4", 1'b1, 1'b0, 64'h7FFF_FFFF * 4, 3'd0, 1'b1);
    apply("R4", 64'h4F00_0000, 1'b0, 3'd0, 1'b0, 1'b1, 6'b0, S32, 1'b1, F_OVF | F_INV);
    apply("R4", 64'h4F00_0000, 1'b0, 3'd0, 1'b1, 1'b1, 6'b0, 64'h8000_0000, 1'b0, 6'b0);
    // R4: limits of the 64-bit destination
    apply("R4", 64'h43E0_0000_0000_0000, 1'b1, 3'd0, 1'b1, 1'b1, 6'b0, S64, 1'b1, F_OVF | F_INV);
    apply("R4", 64'h43D0_0000_0000_0000, 1'b1, 3'd0, 1'b1, 1'b1, 6'b0, 64'h4000_0000_0000_0000, 1'b0, 6'b0);
    apply("R4", 64'hC3E0_0000_0000_0000, 1'b1, 3'd0, 1'b1, 1'b1, 6'b0, S64, 1'b1, F_OVF | F_INV);
    apply("R4", 64'hC3D0_0000_0000_0000, 1'b1, 3'd0, 1'b1, 1'b1, 6'b0, 64'hC000_0000_0000_0000, 1'b0, 6'b0);
    apply("R4", 64'h4450_0000_0000_0000, 1'b1, 3'd1, 1'b1, 1'b1, 6'b0, S64, 1'b1, F_OVF | F_INV);
    apply("R4", 64'h7FF0_0000_0000_0000, 1'b1, 3'd0, 1'b1, 1'b1, 6'b0, S64, 1'b1, F_OVF | F_INV);
    apply("R4", 64'hFF80_0000, 1'b0, 3'd3, 1'b0, 1'b1, 6'b0, S32, 1'b1, F_OVF | F_INV);
    // R5 R6: NaN operands
    apply("R5", 64'h7FF8_0000_0000_0000, 1'b1, 3'd0, 1'b0, 1'b1, 6'b0, S32, 1'b1, F_INV | F_INX);
    apply("R6", 64'h7FC0_0000, 1'b0, 3'd2, 1'b1, 1'b1, 6'b0, S64, 1'b1, F_INV | F_INX);
    // R1 R7: subnormal and signed zero
    apply("R7", 64'h0000_0000_0000_0001, 1'b1, 3'd0, 1'b0, 1'b1, 6'b0, 64'd0, 1'b0, F_INX);
    apply("R1", 64'h0000_0000_0000_0001, 1'b1, 3'd2, 1'b0, 1'b1, 6'b0, 64'd1, 1'b0, F_INX);
    apply("R1", 64'h8000_0001, 1'b0, 3'd1, 1'b0, 1'b1, 6'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, F_INX);
    apply("R1", 64'h8000_0000_0000_0000, 1'b1, 3'd2, 1'b1, 1'b1, 6'b0, 64'd0, 1'b0, 6'b0);

    // R8: flags accumulate without a write, a write clears them
    apply("R8", enc(1'b1, 1'b0, 64'd1), 1'b1, 3'd0, 1'b0, 1'b1, 6'b0, 64'd0, 1'b0, F_INX);
    apply("R8", enc(1'b1, 1'b0, 64'd4), 1'b1, 3'd0, 1'b0, 1'b0, 6'b0, 64'd1, 1'b0, F_INX);
    apply("R8", 64'h7F80_0000, 1'b0, 3'd0, 1'b0, 1'b0, 6'b0, S32, 1'b1, F_INX | F_OVF | F_INV);
    apply("R8", enc(1'b0, 1'b0, 64'd8), 1'b0, 3'd3, 1'b0, 1'b0, 6'b0, 64'd2, 1'b0, F_INX | F_OVF | F_INV);
    write_csr(6'b000010);
    write_csr(6'b000000);

    // R9: conversion reads the old mode while a write lands in the same cycle
    apply("R9", enc(1'b1, 1'b0, 64'd10), 1'b1, 3'd4, 1'b0, 1'b1, 6'b000010, 64'd2, 1'b0, F_INX | 6'b000010);
    cur_mode = 2'd2;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 idle: got v=%b, want 0", out_valid);
    end
    conv("R12", 1'b1, 1'b0, 64'd10, 3'd4, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule